// File: doc/BRIEF.md
# TCP Flow Sequence Tracker

This block watches TCP traffic passively. It keeps one expected sequence number for each flow and decides, frame by frame, where each frame goes. Its input is a summary of one frame's headers: whether the frame is TCP, whether its checksum held, the SYN flag, a flow index that is already hashed, the sequence number and the TCP payload length. It does not reassemble data. Each frame goes to one of three places: the outbound IP path only, both the client application and the IP path, or nowhere.

The checks are applied in a fixed order of precedence. A frame that is not TCP is passed on. A frame with a failed checksum is dropped. A SYN starts the flow's sequence tracking. A frame on a flow with no tracking is passed on. After that the frame's sequence number is compared with the expected value using serial-number arithmetic. A frame that lands exactly on the expected value goes to the client, and the expected value moves past its payload. A frame that is behind is passed on as a retransmission. A frame that is ahead is dropped, because data before it was lost. Each direction of a connection uses its own flow index.

Requests are taken with a valid/ready handshake, and the decision appears one cycle after a request is accepted. The decision is held in a one-deep output register until a downstream ready takes it.

Top module: `tcp_flow_tracker`

## Requirements
- R1: After synchronous reset `dec_valid` is 0 and every flow entry is untracked, so a non-SYN TCP frame with a good checksum on any flow gets code 01.
- R2: A request accepted at a clock edge (`req_valid && req_ready`) gives `dec_valid`=1 after that edge. `req_ready` equals `!dec_valid || dec_ready`. While `dec_valid && !dec_ready`, the decision and the flow stay stable.
- R3: The route codes are 2'b00 = discard, 2'b01 = IP path only and 2'b11 = client and IP path; 2'b10 never appears. A frame with the TCP indicator low gets 01 and leaves its flow's entry unchanged.
- R4: A TCP frame with `req_csum_ok`=0 gets 00 and leaves the entry unchanged, even when SYN is set.
- R5: A TCP frame with a good checksum and SYN set gets 01 and sets its flow's entry to tracked, with an expected value of seq+1 (mod 2^32).
- R6: A non-SYN TCP frame with a good checksum on an untracked flow gets 01 and leaves the entry unchanged.
- R7: On a tracked flow, a frame whose seq equals the expected value gets 11, and the expected value becomes seq+len (mod 2^32).
- R8: On a tracked flow, a frame whose signed 32-bit difference seq-expected is negative gets 01, and the entry is unchanged.
- R9: On a tracked flow, a frame whose signed 32-bit difference seq-expected is positive gets 00, and the entry is unchanged.
- R10: Flows are independent of each other, and the comparison and the update both hold across the 2^32 wrap of the sequence space.
- R11: `dec_flow` carries the flow index of the request that produced the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A frame summary is offered |
| req_ready | output | 1 | The tracker can take a summary |
| req_is_tcp | input | 1 | The frame carries TCP |
| req_csum_ok | input | 1 | The TCP checksum held |
| req_syn | input | 1 | The SYN flag |
| req_flow | input | FLOW_W (8) | Flow index |
| req_seq | input | 32 | TCP sequence number |
| req_len | input | LEN_W (16) | TCP payload length in bytes |
| dec_valid | output | 1 | A decision is present |
| dec_ready | input | 1 | Downstream takes the decision |
| dec_route | output | 2 | Route code: 00 discard, 01 IP only, 11 client and IP |
| dec_flow | output | FLOW_W (8) | Flow index of the decision |

## Verification
The hardest state to reach from the ports is a tracked flow whose expected value sits just below the 2^32 wrap, followed by a frame that crosses the wrap. To get there, a SYN with a chosen sequence number places the expected value 16 below the wrap. An in-order frame then carries it across zero, and frames just behind and just ahead of the new value test the signed comparison. The random phase keeps to four flows. Each sequence number is picked relative to the bench's own model of that flow, as equal, behind or ahead, so in-order hits are frequent. A stalled output is covered by holding `dec_ready` low while a second request waits.

// File: rtl/tcpseq_pkg.sv
package tcpseq_pkg;

    localparam int SEQ_W = 32;

    typedef enum logic [1:0] {
        RT_DROP = 2'b00,
        RT_IP   = 2'b01,
        RT_BOTH = 2'b11
    } route_e;

    typedef struct packed {
        logic             wr;
        logic [SEQ_W-1:0] wr_seq;
        route_e           route;
    } verdict_t;

    // serial-number difference a-b interpreted as signed
    function automatic logic signed [SEQ_W-1:0] seq_delta(
        input logic [SEQ_W-1:0] a,
        input logic [SEQ_W-1:0] b
    );
        return $signed(a - b);
    endfunction

endpackage

// File: rtl/flow_state_table.sv
module flow_state_table
    import tcpseq_pkg::*;
#(
    parameter int FLOW_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FLOW_W-1:0] rd_idx,
    output logic              rd_tracked,
    output logic [SEQ_W-1:0]  rd_seq,
    input  logic              wr_en,
    input  logic [FLOW_W-1:0] wr_idx,
    input  logic [SEQ_W-1:0]  wr_seq
);
    localparam int NFLOW = 1 << FLOW_W;

    logic             tracked [NFLOW];
    logic [SEQ_W-1:0] expect_q [NFLOW];

    for (genvar g = 0; g < NFLOW; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                tracked[g] <= 1'b0;
            end else if (wr_en && wr_idx == FLOW_W'(g)) begin
                tracked[g] <= 1'b1;
            end
        end
        always_ff @(posedge clk) begin
            if (wr_en && wr_idx == FLOW_W'(g)) begin
                expect_q[g] <= wr_seq;
            end
        end
    end

    assign rd_tracked = tracked[rd_idx];
    assign rd_seq     = expect_q[rd_idx];

endmodule

// File: rtl/flow_verdict.sv
module flow_verdict
    import tcpseq_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             is_tcp,
    input  logic             csum_ok,
    input  logic             syn,
    input  logic [SEQ_W-1:0] seq,
    input  logic [LEN_W-1:0] len,
    input  logic             ent_tracked,
    input  logic [SEQ_W-1:0] ent_seq,
    output verdict_t         verdict
);
    logic signed [SEQ_W-1:0] delta;

    assign delta = seq_delta(seq, ent_seq);

    always_comb begin
        verdict.wr     = 1'b0;
        verdict.wr_seq = '0;
        verdict.route  = RT_IP;
        if (!is_tcp) begin
            verdict.route = RT_IP;
        end else if (!csum_ok) begin
            verdict.route = RT_DROP;
        end else if (syn) begin
            verdict.route  = RT_IP;
            verdict.wr     = 1'b1;
            verdict.wr_seq = seq + SEQ_W'(1);
        end else if (!ent_tracked) begin
            verdict.route = RT_IP;
        end else if (delta < 0) begin
            verdict.route = RT_IP;
        end else if (delta > 0) begin
            verdict.route = RT_DROP;
        end else begin
            verdict.route  = RT_BOTH;
            verdict.wr     = 1'b1;
            verdict.wr_seq = seq + SEQ_W'(len);
        end
    end

    // R4: a failed checksum never touches the table
    always_comb begin
        if (is_tcp && !csum_ok) begin
            a_nowrite_badsum_r4: assert (!verdict.wr);
        end
    end

endmodule

// File: rtl/decision_stage.sv
module decision_stage
    import tcpseq_pkg::*;
#(
    parameter int FLOW_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_fire,
    input  route_e            in_route,
    input  logic [FLOW_W-1:0] in_flow,
    output logic              in_ready,
    output logic              out_valid,
    input  logic              out_ready,
    output route_e            out_route,
    output logic [FLOW_W-1:0] out_flow
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_route <= RT_DROP;
            out_flow  <= '0;
        end else if (in_fire) begin
            out_valid <= 1'b1;
            out_route <= in_route;
            out_flow  <= in_flow;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign in_ready = !out_valid || out_ready;

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_route) && $stable(out_flow)));

    p_code_r3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_route != 2'b10));

endmodule

// File: rtl/tcp_flow_tracker.sv
module tcp_flow_tracker
    import tcpseq_pkg::*;
#(
    parameter int FLOW_W = 8,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_is_tcp,
    input  logic              req_csum_ok,
    input  logic              req_syn,
    input  logic [FLOW_W-1:0] req_flow,
    input  logic [31:0]       req_seq,
    input  logic [LEN_W-1:0]  req_len,
    output logic              dec_valid,
    input  logic              dec_ready,
    output logic [1:0]        dec_route,
    output logic [FLOW_W-1:0] dec_flow
);
    logic             fire;
    logic             ent_tracked;
    logic [SEQ_W-1:0] ent_seq;
    verdict_t         verdict;
    route_e           route_q;

    assign fire = req_valid && req_ready;

    flow_state_table #(.FLOW_W(FLOW_W)) u_table (
        .clk        (clk),
        .rst        (rst),
        .rd_idx     (req_flow),
        .rd_tracked (ent_tracked),
        .rd_seq     (ent_seq),
        .wr_en      (fire && verdict.wr),
        .wr_idx     (req_flow),
        .wr_seq     (verdict.wr_seq)
    );

    flow_verdict #(.LEN_W(LEN_W)) u_verdict (
        .is_tcp      (req_is_tcp),
        .csum_ok     (req_csum_ok),
        .syn         (req_syn),
        .seq         (req_seq),
        .len         (req_len),
        .ent_tracked (ent_tracked),
        .ent_seq     (ent_seq),
        .verdict     (verdict)
    );

    decision_stage #(.FLOW_W(FLOW_W)) u_stage (
        .clk       (clk),
        .rst       (rst),
        .in_fire   (fire),
        .in_route  (verdict.route),
        .in_flow   (req_flow),
        .in_ready  (req_ready),
        .out_valid (dec_valid),
        .out_ready (dec_ready),
        .out_route (route_q),
        .out_flow  (dec_flow)
    );

    assign dec_route = route_q;

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        fire |=> dec_valid);

    p_nontcp_r3: assert property (@(posedge clk) disable iff (rst)
        (fire && !req_is_tcp) |=> (dec_route == RT_IP));

    p_badsum_r4: assert property (@(posedge clk) disable iff (rst)
        (fire && req_is_tcp && !req_csum_ok) |=> (dec_route == RT_DROP));

    p_syn_r5: assert property (@(posedge clk) disable iff (rst)
        (fire && req_is_tcp && req_csum_ok && req_syn) |=> (dec_route == RT_IP));

    p_flow_echo_r11: assert property (@(posedge clk) disable iff (rst)
        fire |=> (dec_flow == $past(req_flow)));

endmodule

// File: tb/sim_tcp_flow_tracker.sv
module sim_tcp_flow_tracker;
    localparam int FW = 8;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_is_tcp = 1'b0;
    logic          req_csum_ok = 1'b0;
    logic          req_syn = 1'b0;
    logic [FW-1:0] req_flow = '0;
    logic [31:0]   req_seq = '0;
    logic [LW-1:0] req_len = '0;
    logic          dec_valid;
    logic          dec_ready = 1'b1;
    logic [1:0]    dec_route;
    logic [FW-1:0] dec_flow;

    int vectors = 0;
    int miscompares = 0;

    logic        m_trk [256];
    logic [31:0] m_exp [256];

    always #5 clk = ~clk;

    tcp_flow_tracker #(.FLOW_W(FW), .LEN_W(LW)) u0 (.*);

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // reference decision, updates the model
    function automatic logic [1:0] model(input logic tcp, input logic ok, input logic syn,
                                         input int f, input logic [31:0] seq, input logic [15:0] len);
        logic signed [31:0] d;
        if (!tcp) return 2'b01;
        if (!ok) return 2'b00;
        if (syn) begin
            m_trk[f] = 1'b1;
            m_exp[f] = seq + 32'd1;
            return 2'b01;
        end
        if (!m_trk[f]) return 2'b01;
        d = $signed(seq - m_exp[f]);
        if (d < 0) return 2'b01;
        if (d > 0) return 2'b00;
        m_exp[f] = seq + {16'd0, len};
        return 2'b11;
    endfunction

    task automatic send(input string tag, input logic tcp, input logic ok, input logic syn,
                        input int f, input logic [31:0] seq, input logic [15:0] len);
        logic [1:0] e;
        e = model(tcp, ok, syn, f, seq, len);
        @(negedge clk);
        req_valid = 1'b1; req_is_tcp = tcp; req_csum_ok = ok; req_syn = syn;
        req_flow = FW'(f); req_seq = seq; req_len = len;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " valid R2"}, {31'd0, dec_valid}, 32'd1);
        check(tag, {30'd0, dec_route}, {30'd0, e});
        check({tag, " flow R11"}, {24'd0, dec_flow}, f);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        logic [1:0] e1;
        logic [1:0] e2;
        void'($urandom(32'h5eed_0042));
        for (int i = 0; i < 256; i++) begin m_trk[i] = 1'b0; m_exp[i] = '0; end
        repeat (3) @(negedge clk);
        check("R1 dec_valid at reset", {31'd0, dec_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", {31'd0, dec_valid}, 32'd0);
        check("R2 ready idle", {31'd0, req_ready}, 32'd1);

        send("R1/R6 untracked flow 7", 1, 1, 0, 7, 32'h100, 16'd10);
        send("R3 non-TCP", 0, 1, 1, 7, 32'h100, 16'd10);
        send("R6 still untracked after R3", 1, 1, 0, 7, 32'h101, 16'd10);
        send("R4 bad csum with SYN", 1, 0, 1, 7, 32'h500, 16'd0);
        send("R4 no track after bad SYN", 1, 1, 0, 7, 32'h501, 16'd4);
        send("R5 SYN", 1, 1, 1, 7, 32'h1000, 16'd0);
        send("R7 in-order", 1, 1, 0, 7, 32'h1001, 16'd100);
        send("R8 behind", 1, 1, 0, 7, 32'h1001, 16'd100);
        send("R9 ahead", 1, 1, 0, 7, 32'h2000, 16'd8);
        send("R4 bad csum in-order", 1, 0, 0, 7, 32'h1065, 16'd8);
        send("R7 after drops", 1, 1, 0, 7, 32'h1065, 16'd8);
        send("R10 other flow untracked", 1, 1, 0, 8, 32'h106d, 16'd8);
        send("R7 zero length", 1, 1, 0, 7, 32'h106d, 16'd0);
        send("R7 same seq again", 1, 1, 0, 7, 32'h106d, 16'd3);

        send("R5 SYN near wrap", 1, 1, 1, 5, 32'hFFFF_FFEF, 16'd0);
        send("R10 cross wrap", 1, 1, 0, 5, 32'hFFFF_FFF0, 16'h20);
        send("R10 after wrap", 1, 1, 0, 5, 32'h0000_0010, 16'd4);
        send("R10 behind across wrap", 1, 1, 0, 5, 32'hFFFF_FFF8, 16'd4);
        send("R10 ahead after wrap", 1, 1, 0, 5, 32'h0000_0100, 16'd4);
        send("R10 flow 7 unaffected", 1, 1, 0, 7, 32'h1070, 16'd1);

        // stall: first decision held while second request waits
        e1 = model(1, 1, 1, 9, 32'h40, 16'd0);
        e2 = model(1, 1, 0, 9, 32'h41, 16'd2);
        @(negedge clk);
        dec_ready = 1'b0;
        req_valid = 1'b1; req_is_tcp = 1; req_csum_ok = 1; req_syn = 1;
        req_flow = 8'd9; req_seq = 32'h40; req_len = 0;
        @(negedge clk);
        req_syn = 0; req_seq = 32'h41; req_len = 16'd2;
        check("R2 stall ready low", {31'd0, req_ready}, 32'd0);
        check("R2 stall first route", {30'd0, dec_route}, {30'd0, e1});
        repeat (2) @(negedge clk);
        check("R2 held valid", {31'd0, dec_valid}, 32'd1);
        check("R2 held route", {30'd0, dec_route}, {30'd0, e1});
        dec_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R2 second after release", {30'd0, dec_route}, {30'd0, e2});
        @(negedge clk);
        check("R2 drained", {31'd0, dec_valid}, 32'd0);

        // random phase on four flows
        for (int i = 0; i < 400; i++) begin
            int f;
            int k;
            logic [31:0] s;
            logic [15:0] l;
            f = 20 + int'($urandom_range(0, 3));
            k = int'($urandom_range(0, 9));
            l = 16'($urandom_range(0, 1500));
            s = m_exp[f];
            if (k == 0)      send("R5 rnd SYN", 1, 1, 1, f, $urandom, l);
            else if (k == 1) send("R3 rnd non-TCP", 0, $urandom_range(0, 1) == 1, 0, f, s, l);
            else if (k == 2) send("R4 rnd bad csum", 1, 0, 0, f, s, l);
            else if (k == 3) send("R8 rnd behind", 1, 1, 0, f, s - 32'($urandom_range(1, 70000)), l);
            else if (k == 4) send("R9 rnd ahead", 1, 1, 0, f, s + 32'($urandom_range(1, 70000)), l);
            else             send("R7 rnd in-order", 1, 1, 0, f, s, l);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule